// File: doc/BRIEF.md
# Transmit Preamble and Header Serializer

This block turns the parameters of one outgoing physical-layer frame into the serial bit stream of its preamble and header. A single start strobe captures the 8-bit rate code, the 8-bit service byte, the 16-bit length word and a mode select. The mode select chooses a long or a short preamble. The block then waits for bit-enable ticks from the modulator's bit clock and emits exactly one bit per tick.

The stream contains a run of synchronisation bits and a 16-bit delimiter. The three header fields follow, and then a 16-bit check word. The check word is computed on the fly as the header bits leave. It is sent complemented and most significant bit first. After the last check bit the block pulses done and returns to idle, ready for the next frame. Payload transmission and scrambling are left to the stages downstream.

Top module: `plcp_hdr_tx`

## Requirements
- R1: While reset is held, and in the first cycle after it, `bit_valid_o`, `done_o` and `busy_o` are low.
- R2: A `start_i` seen while idle captures `sig_i`, `svc_i`, `len_i` and `short_pre_i` and raises `busy_o` on the next cycle. Later changes on those inputs have no effect on the frame in progress.
- R3: A `start_i` seen while `busy_o` is high is ignored. The current frame continues bit for bit and no second frame follows it.
- R4: Each `bit_en_i` tick sampled while busy produces exactly one bit, with `bit_valid_o` high in the following cycle. Without ticks the frame does not advance, and ticks while idle produce nothing.
- R5: In long mode (`short_pre_i`=0) the frame opens with 128 one bits. These are followed by the delimiter word 0xF3A0, sent bit 0 first.
- R6: In short mode (`short_pre_i`=1) the frame opens with 56 zero bits. These are followed by the delimiter word 0x05CF (0xF3A0 with its bits reversed), sent bit 0 first.
- R7: After the delimiter come the rate code (8 bits), the service byte (8 bits) and the length word (16 bits), in that order and each sent bit 0 first.
- R8: The last 16 bits are a check word over the 32 header bits in transmit order. It uses the polynomial x^16+x^12+x^5+1 with the register preset to 0xFFFF. The final remainder is complemented and sent bit 15 first.
- R9: `done_o` is high for one cycle, together with `bit_valid_o` of the last check bit, and `busy_o` is low in that cycle. A frame holds 192 bits in long mode and 120 bits in short mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame (taken only while idle) |
| short_pre_i | input | 1 | 1 selects the short preamble, 0 the long one |
| sig_i | input | 8 | Rate code field |
| svc_i | input | 8 | Service field |
| len_i | input | 16 | Length field |
| bit_en_i | input | 1 | Bit-enable tick from the bit clock |
| bit_o | output | 1 | Serial output bit |
| bit_valid_o | output | 1 | `bit_o` carries a new bit this cycle |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | Last bit of the frame is on `bit_o` |

## Verification
The stream is driven with continuous ticks, with a tick every third cycle and with a pseudo-random tick pattern. This separates an output that follows the ticks from one that runs on the clock. Long and short frames are interleaved, which shows whether the sync polarity, the sync length and the delimiter orientation each follow the captured mode. Header values of all zeros, all ones and mixed patterns tell a correct check word apart from one that is uncomplemented, reflected or preset wrongly. Mid-frame starts carrying different field values, and frames started on the cycle after done, show that capture happens only while idle.

// File: rtl/plcp_hdr_pkg.sv
package plcp_hdr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SYNC = 3'd1,
    PH_SFD  = 3'd2,
    PH_SIG  = 3'd3,
    PH_SVC  = 3'd4,
    PH_LEN  = 3'd5,
    PH_CRC  = 3'd6
  } phase_e;

  localparam logic [15:0] CRC16_POLY   = 16'h1021;
  localparam logic [15:0] CRC16_PRESET = 16'hFFFF;
  localparam logic [15:0] SFD_LONG     = 16'hF3A0;

  function automatic phase_e next_phase(phase_e p);
    case (p)
      PH_SYNC: return PH_SFD;
      PH_SFD:  return PH_SIG;
      PH_SIG:  return PH_SVC;
      PH_SVC:  return PH_LEN;
      PH_LEN:  return PH_CRC;
      default: return PH_IDLE;
    endcase
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/plcp_phase_seq.sv
module plcp_phase_seq
  import plcp_hdr_pkg::*;
#(
  parameter int unsigned LONG_SYNC_BITS  = 128,
  parameter int unsigned SHORT_SYNC_BITS = 56,
  parameter int unsigned SFD_BITS        = 16,
  parameter int unsigned SIG_BITS        = 8,
  parameter int unsigned SVC_BITS        = 8,
  parameter int unsigned LEN_BITS        = 16,
  parameter int unsigned CRC_BITS        = 16,
  localparam int unsigned MAX_SPAN = max2(max2(max2(LONG_SYNC_BITS, SHORT_SYNC_BITS),
                                               max2(SFD_BITS, CRC_BITS)),
                                          max2(max2(SIG_BITS, SVC_BITS), LEN_BITS)),
  localparam int unsigned IDX_W    = $clog2(MAX_SPAN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             short_i,
  input  logic             tick_i,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             adv_o,
  output logic             final_o
);

  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;
  logic             at_end;
  logic             adv;

  function automatic int unsigned span(phase_e p, logic shrt);
    case (p)
      PH_SYNC: return shrt ? SHORT_SYNC_BITS : LONG_SYNC_BITS;
      PH_SFD:  return SFD_BITS;
      PH_SIG:  return SIG_BITS;
      PH_SVC:  return SVC_BITS;
      PH_LEN:  return LEN_BITS;
      PH_CRC:  return CRC_BITS;
      default: return 1;
    endcase
  endfunction

  always_comb begin
    last_idx = IDX_W'(span(phase_q, short_i) - 1);
    at_end   = (idx_q == last_idx);
    adv      = (phase_q != PH_IDLE) && tick_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else if (accept_i && phase_q == PH_IDLE) begin
      phase_q <= PH_SYNC;
      idx_q   <= '0;
    end else if (adv) begin
      if (at_end) begin
        phase_q <= next_phase(phase_q);
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign adv_o   = adv;
  assign final_o = adv && at_end && (phase_q == PH_CRC);

  // R4: the position inside the frame moves only on a tick
  assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && !tick_i) |=> ($stable(phase_q) && $stable(idx_q)));

  // R9: the bit index never runs past the span of its phase
  assert_idx_in_span_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> (int'(idx_q) < int'(span(phase_q, short_i))));

  // R9: leaving the check-word phase always ends the frame
  assert_crc_exit_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CRC && adv && at_end) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/plcp_crc_unit.sv
module plcp_crc_unit #(
  parameter int unsigned       CRC_W  = 16,
  parameter logic [CRC_W-1:0]  POLY   = 16'h1021,
  parameter logic [CRC_W-1:0]  PRESET = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             step_i,
  input  logic             shift_i,
  input  logic             din_i,
  output logic [CRC_W-1:0] crc_o,
  output logic             out_bit_o
);

  logic [CRC_W-1:0] crc_q;

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= PRESET;
    end else if (init_i) begin
      crc_q <= PRESET;
    end else if (step_i) begin
      crc_q <= crc_step(crc_q, din_i);
    end else if (shift_i) begin
      crc_q <= {crc_q[CRC_W-2:0], 1'b1};
    end
  end

  assign crc_o     = crc_q;
  assign out_bit_o = ~crc_q[CRC_W-1];

  // R8: a fresh frame always starts from the preset value
  assert_preset_on_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (crc_q == PRESET));

  // R8: register only changes when fed, shifted or preset
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !step_i && !shift_i) |=> $stable(crc_q));

endmodule

// File: rtl/plcp_hdr_tx.sv
module plcp_hdr_tx
  import plcp_hdr_pkg::*;
#(
  parameter int unsigned       LONG_SYNC_BITS  = 128,
  parameter int unsigned       SHORT_SYNC_BITS = 56,
  parameter int unsigned       SFD_BITS        = 16,
  parameter logic [SFD_BITS-1:0] SFD_WORD      = SFD_LONG,
  parameter int unsigned       SIG_BITS        = 8,
  parameter int unsigned       SVC_BITS        = 8,
  parameter int unsigned       LEN_BITS        = 16,
  parameter int unsigned       CRC_BITS        = 16,
  localparam int unsigned      HDR_BITS = SIG_BITS + SVC_BITS + LEN_BITS,
  localparam int unsigned      HPOS_W   = $clog2(HDR_BITS),
  localparam int unsigned      SPOS_W   = $clog2(SFD_BITS),
  localparam int unsigned      MAX_SPAN = max2(max2(max2(LONG_SYNC_BITS, SHORT_SYNC_BITS),
                                                    max2(SFD_BITS, CRC_BITS)),
                                               max2(max2(SIG_BITS, SVC_BITS), LEN_BITS)),
  localparam int unsigned      IDX_W    = $clog2(MAX_SPAN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                short_pre_i,
  input  logic [SIG_BITS-1:0] sig_i,
  input  logic [SVC_BITS-1:0] svc_i,
  input  logic [LEN_BITS-1:0] len_i,
  input  logic                bit_en_i,
  output logic                bit_o,
  output logic                bit_valid_o,
  output logic                busy_o,
  output logic                done_o
);

  // captured frame parameters
  logic                short_q;
  logic [HDR_BITS-1:0] hdr_q;

  // sequencer events
  phase_e           phase;
  logic [IDX_W-1:0] idx;
  logic             adv;
  logic             final_bit;
  logic             accept;

  // bit selection
  logic [SFD_BITS-1:0] sfd_short;
  logic [SFD_BITS-1:0] sfd_sel;
  logic [HPOS_W-1:0]   hpos;
  logic                in_header;
  logic                cur_bit;

  // check word
  logic [CRC_BITS-1:0] crc_val;
  logic                crc_bit;

  // output registers
  logic bit_q, valid_q, done_q;

  assign accept = start_i && (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      short_q <= 1'b0;
      hdr_q   <= '0;
    end else if (accept) begin
      short_q <= short_pre_i;
      hdr_q   <= {len_i, svc_i, sig_i};
    end
  end

  // short delimiter is the long word mirrored
  for (genvar g = 0; g < int'(SFD_BITS); g++) begin : g_sfd_mirror
    assign sfd_short[g] = SFD_WORD[SFD_BITS-1-g];
  end

  assign sfd_sel = short_q ? sfd_short : SFD_WORD;

  always_comb begin
    case (phase)
      PH_SVC:  hpos = HPOS_W'(SIG_BITS) + HPOS_W'(idx);
      PH_LEN:  hpos = HPOS_W'(SIG_BITS + SVC_BITS) + HPOS_W'(idx);
      default: hpos = HPOS_W'(idx);
    endcase
    in_header = (phase == PH_SIG) || (phase == PH_SVC) || (phase == PH_LEN);
  end

  always_comb begin
    case (phase)
      PH_SYNC: cur_bit = ~short_q;
      PH_SFD:  cur_bit = sfd_sel[SPOS_W'(idx)];
      PH_SIG,
      PH_SVC,
      PH_LEN:  cur_bit = hdr_q[hpos];
      PH_CRC:  cur_bit = crc_bit;
      default: cur_bit = 1'b0;
    endcase
  end

  plcp_phase_seq #(
    .LONG_SYNC_BITS (LONG_SYNC_BITS),
    .SHORT_SYNC_BITS(SHORT_SYNC_BITS),
    .SFD_BITS       (SFD_BITS),
    .SIG_BITS       (SIG_BITS),
    .SVC_BITS       (SVC_BITS),
    .LEN_BITS       (LEN_BITS),
    .CRC_BITS       (CRC_BITS)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept_i(accept),
    .short_i (short_q),
    .tick_i  (bit_en_i),
    .phase_o (phase),
    .idx_o   (idx),
    .adv_o   (adv),
    .final_o (final_bit)
  );

  plcp_crc_unit #(
    .CRC_W (CRC_BITS),
    .POLY  (CRC_BITS'(CRC16_POLY)),
    .PRESET(CRC_BITS'(CRC16_PRESET))
  ) crc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (accept),
    .step_i   (adv && in_header),
    .shift_i  (adv && (phase == PH_CRC)),
    .din_i    (cur_bit),
    .crc_o    (crc_val),
    .out_bit_o(crc_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= adv;
      done_q  <= final_bit;
      if (adv) bit_q <= cur_bit;
    end
  end

  assign bit_o       = bit_q;
  assign bit_valid_o = valid_q;
  assign done_o      = done_q;
  assign busy_o      = (phase != PH_IDLE);

  // R4: every output bit is the answer to a tick one cycle earlier
  assert_valid_follows_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> $past(bit_en_i));

  // R9: done marks the last bit and the block is idle again
  assert_done_on_last_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bit_valid_o && !busy_o));

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2: captured fields do not move while a frame runs
  assert_capture_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(hdr_q) && $stable(short_q)));

  // R3: a start during a frame does not cut it short
  assert_busy_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !final_bit) |=> busy_o);

  // R8: each frame begins its check word from the preset
  assert_crc_preset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (crc_val == CRC_BITS'(CRC16_PRESET)));

  // R1: nothing is emitted in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!bit_valid_o && !done_o && !busy_o));

endmodule

// File: tb/plcp_hdr_tx_tb_top.sv
`timescale 1ns/1ps
module plcp_hdr_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        short_pre = 1'b0;
  logic [7:0]  sig = '0;
  logic [7:0]  svc = '0;
  logic [15:0] len = '0;
  logic        bit_en = 1'b0;
  logic        bit_o, bit_valid, busy, done;

  int checks = 0;
  int fails  = 0;

  bit    exp_q[$];
  string tag_q[$];
  bit    m_busy  = 0;
  int    m_count = 0;
  int    m_total = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  plcp_hdr_tx dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .short_pre_i(short_pre),
    .sig_i      (sig),
    .svc_i      (svc),
    .len_i      (len),
    .bit_en_i   (bit_en),
    .bit_o      (bit_o),
    .bit_valid_o(bit_valid),
    .busy_o     (busy),
    .done_o     (done)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected stream built from the requirements
  task automatic build_frame(bit shrt, logic [7:0] s, logic [7:0] v, logic [15:0] l);
    logic [15:0] delim = 16'hF3A0;
    bit          msg[32];
    logic [47:0] d;
    exp_q.delete();
    tag_q.delete();
    for (int i = 0; i < (shrt ? 56 : 128); i++) begin
      exp_q.push_back(!shrt);
      tag_q.push_back(shrt ? "R6 sync" : "R5 sync");
    end
    for (int i = 0; i < 16; i++) begin
      exp_q.push_back(shrt ? delim[15-i] : delim[i]);
      tag_q.push_back(shrt ? "R6 delimiter" : "R5 delimiter");
    end
    for (int i = 0; i < 8; i++)  msg[i]      = s[i];
    for (int i = 0; i < 8; i++)  msg[8+i]    = v[i];
    for (int i = 0; i < 16; i++) msg[16+i]   = l[i];
    for (int i = 0; i < 32; i++) begin
      exp_q.push_back(msg[i]);
      tag_q.push_back("R7 header");
    end
    // long division with preset folded into the leading bits
    d = '0;
    for (int i = 0; i < 32; i++) d[47-i] = msg[i];
    d[47:32] = d[47:32] ^ 16'hFFFF;
    for (int i = 47; i >= 16; i--)
      if (d[i]) d[i -: 17] = d[i -: 17] ^ 17'h11021;
    for (int i = 0; i < 16; i++) begin
      exp_q.push_back(!d[15-i]);
      tag_q.push_back("R8 check word");
    end
    m_total = exp_q.size();
  endtask

  task automatic cyc(bit en, bit st);
    bit    ev = 0, ed = 0, eb = 0;
    string et = "R4";
    bit_en = en;
    start  = st;
    @(posedge clk);
    if (m_busy && en) begin
      ev = 1;
      eb = exp_q.pop_front();
      et = tag_q.pop_front();
      m_count++;
      if (exp_q.size() == 0) begin
        ed = 1;
        m_busy = 0;
      end
    end else if (!m_busy && st) begin
      build_frame(short_pre, sig, svc, len);
      m_busy  = 1;
      m_count = 0;
    end
    @(negedge clk);
    check(bit_valid === ev, "R4", "bit_valid", int'(bit_valid), int'(ev));
    if (ev) check(bit_o === eb, et, "bit", int'(bit_o), int'(eb));
    check(done === ed, "R9", "done", int'(done), int'(ed));
    check(busy === m_busy, st ? "R3" : "R2", "busy", int'(busy), int'(m_busy));
    if (ed) check(m_count == m_total, "R9", "frame length", m_count, m_total);
  endtask

  function automatic bit tick_of(int mode, int n);
    case (mode)
      0:       return 1'b1;
      1:       return (n % 3) == 2;
      default: return lfsr[0] ^ lfsr[5];
    endcase
  endfunction

  task automatic run_frame(bit shrt, logic [7:0] s, logic [7:0] v, logic [15:0] l, int mode);
    int n = 0;
    short_pre = shrt;
    sig = s;
    svc = v;
    len = l;
    cyc(mode == 2, 1'b1);
    while (m_busy) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (n == 20) begin
        // R2: field inputs move after capture
        sig = ~s; svc = s; len = ~l; short_pre = !shrt;
      end
      // R3: a start in the middle of the frame
      cyc(tick_of(mode, n), (n == 40) || (n == 41));
      n++;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL R4 watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(bit_valid === 1'b0, "R1", "bit_valid in reset", int'(bit_valid), 0);
    check(done === 1'b0, "R1", "done in reset", int'(done), 0);
    check(busy === 1'b0, "R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && bit_valid === 1'b0, "R1", "idle after reset",
          int'(busy) + int'(bit_valid), 0);

    // R4: ticks with no frame produce nothing
    repeat (5) cyc(1'b1, 1'b0);

    run_frame(1'b0, 8'h0A, 8'h00, 16'h0010, 0);   // R5 long, continuous ticks
    run_frame(1'b1, 8'h14, 8'h04, 16'h1234, 1);   // R6 short, sparse ticks
    run_frame(1'b0, 8'h6E, 8'h80, 16'hFFFF, 2);   // R8 pseudo-random ticks
    run_frame(1'b1, 8'h00, 8'h00, 16'h0000, 2);   // R8 all-zero header
    run_frame(1'b0, 8'hFF, 8'hFF, 16'hFFFF, 1);   // R8 all-ones header
    run_frame(1'b1, 8'h37, 8'h5A, 16'hBEEF, 0);   // back-to-back after done

    // R3: no second frame after an ignored start
    repeat (6) cyc(1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule